// File: doc/BRIEF.md
# Dual-Socket Video Port Control Registers

This block keeps the video-port control state of a two-socket card controller and drives the selects of the external video multiplexer. Software reaches it through a single-cycle register interface. One space holds per-socket registers: a present-state word, a force-event word and a control word. A second space holds two configuration bytes: a per-socket legacy card-control byte and a shared diagnostic byte.

Each socket has two enable sources. One is a standardized enable bit in its control word. The other is a legacy enable bit in its card-control byte. The diagnostic byte can switch the standardized model off. The effective enables of the two sockets produce three registered outputs: two one-hot select lines that pick the socket feeding the video port, and an active-high status line. The status line tells external logic that card video has priority over a third video source. The video-support flag of each socket cannot be written where it is read. It can only be set through that socket's force-event word.

Top module: `zv_port_ctrl`

## Requirements
- R1: In the socket space (bus_cfg=0), offset 08h returns the socket's video-support flag in bit 27 and 0 in all other bits. The flag is 0 after reset, and writes to offset 08h never change it.
- R2: Writing offset 0Ch with bit 27 set makes the support flag of the addressed socket 1, leaving the other socket's flag alone. A write with bit 27 clear has no effect. Only reset clears the flag. Offset 0Ch always reads 0.
- R3: While the standardized model is on, bit 9 of offset 10h is a per-socket enable that software writes and reads back.
- R4: Bit 10 of offset 10h reads 1 while the standardized model is on and 0 while it is off.
- R5: While the model is on, bit 11 of offset 10h reads 1 in both sockets' words exactly when at least one socket is effectively enabled.
- R6: In the configuration space (bus_cfg=1), bit 0 of the byte at 93h turns the standardized model off when 1. While it is off, writes to bit 9 of offset 10h leave the stored enable unchanged, bits 9 to 11 of offset 10h read 0, and the stored enable does not count toward the effective enable.
- R7: In the configuration space, bit 6 of the byte at 91h is the addressed socket's legacy enable. It is written and read back whatever the diagnostic bit is. A socket's effective enable is its legacy enable OR its standardized enable while the model is on.
- R8: zv_status is high exactly when at least one socket is effectively enabled. It follows a register write with one cycle of latency.
- R9: zv_sel_a is high when only socket A is effective and zv_sel_b is high when only socket B is effective. When both are effective, port_pick selects A (0) or B (1). When neither is effective, both selects are low. The selects are never high together.
- R10: Asserting rst_n low at once forces all outputs low and clears every enable, support flag and the diagnostic bit. Registers come out of reset two clock edges after rst_n rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_cfg | input | 1 | 0 selects the socket space, 1 selects the configuration bytes |
| bus_sock | input | 1 | Addressed socket, 0 for A and 1 for B |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for the current address |
| port_pick | input | 1 | Socket preference when both sockets are enabled |
| zv_sel_a | output | 1 | Routes socket A to the video port |
| zv_sel_b | output | 1 | Routes socket B to the video port |
| zv_status | output | 1 | High when either socket drives video |

## Verification
The bench sweeps all 64 combinations of diagnostic bit, both standardized enables, both legacy enables and port_pick. Each combination checks the two selects, the status line and both control words. This sweep separates the OR of the two enable paths from the gating by the diagnostic bit, and the both-enabled tie-break from the single-socket cases. Separate patterns write the control enable while the model is off and read it back after turning the model on, which shows the write was ignored rather than masked on read. Other patterns write zero and one to the force-event bit of one socket and try a direct write to the present-state word, which tells the sticky set path apart from a plain register. A reset applied in the middle of operation shows that the outputs clear at once and that the state is gone after release.

// File: rtl/zv_pkg.sv
package zv_pkg;
  localparam int ZV_DATA_W   = 32;
  localparam int ZV_ADDR_W   = 8;
  localparam int ZV_NSOCK    = 2;

  localparam logic [ZV_ADDR_W-1:0] OFS_PRESENT = 8'h08;
  localparam logic [ZV_ADDR_W-1:0] OFS_FORCE   = 8'h0C;
  localparam logic [ZV_ADDR_W-1:0] OFS_CTRL    = 8'h10;
  localparam logic [ZV_ADDR_W-1:0] OFS_LEGACY  = 8'h91;
  localparam logic [ZV_ADDR_W-1:0] OFS_DIAG    = 8'h93;

  localparam int SUPP_BIT  = 27;
  localparam int EN_BIT    = 9;
  localparam int MODEL_BIT = 10;
  localparam int ACT_BIT   = 11;
  localparam int LEG_BIT   = 6;
  localparam int DIAG_BIT  = 0;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_PRESENT,
    ACC_FORCE,
    ACC_CTRL,
    ACC_LEGACY,
    ACC_DIAG
  } zv_acc_e;

  function automatic zv_acc_e zv_decode(input logic cfg, input logic [ZV_ADDR_W-1:0] addr);
    zv_acc_e a;
    a = ACC_NONE;
    if (!cfg) begin
      if (addr == OFS_PRESENT)      a = ACC_PRESENT;
      else if (addr == OFS_FORCE)   a = ACC_FORCE;
      else if (addr == OFS_CTRL)    a = ACC_CTRL;
    end else begin
      if (addr == OFS_LEGACY)       a = ACC_LEGACY;
      else if (addr == OFS_DIAG)    a = ACC_DIAG;
    end
    return a;
  endfunction
endpackage

// File: rtl/zv_rst_sync.sv
module zv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/zv_sock_regs.sv
module zv_sock_regs (
  input  logic clk,
  input  logic rst_n,
  input  logic std_on,
  input  logic wr_force,
  input  logic force_bit,
  input  logic wr_ctrl,
  input  logic ctrl_bit,
  input  logic wr_legacy,
  input  logic legacy_bit,
  output logic supp,
  output logic std_en,
  output logic leg_en,
  output logic eff_en
);
  logic supp_d, std_en_d, leg_en_d;
  logic std_we, leg_we, supp_we;

  always_comb begin
    supp_we  = wr_force && force_bit;
    std_we   = wr_ctrl && std_on;
    leg_we   = wr_legacy;
    supp_d   = supp_we ? 1'b1 : supp;
    std_en_d = std_we ? ctrl_bit : std_en;
    leg_en_d = leg_we ? legacy_bit : leg_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      supp   <= 1'b0;
      std_en <= 1'b0;
      leg_en <= 1'b0;
    end else begin
      supp   <= supp_d;
      std_en <= std_en_d;
      leg_en <= leg_en_d;
    end
  end

  assign eff_en = leg_en | (std_en & std_on);

  // R2
  supp_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    supp |=> supp);

  // R6
  std_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!std_on && wr_ctrl) |=> $stable(std_en));
endmodule

// File: rtl/zv_sel_encode.sv
module zv_sel_encode (
  input  logic clk,
  input  logic rst_n,
  input  logic eff_a,
  input  logic eff_b,
  input  logic pick_b,
  output logic sel_a,
  output logic sel_b,
  output logic status
);
  logic sel_a_d, sel_b_d, status_d;

  always_comb begin
    sel_a_d  = 1'b0;
    sel_b_d  = 1'b0;
    unique case ({eff_a, eff_b})
      2'b10:   sel_a_d = 1'b1;
      2'b01:   sel_b_d = 1'b1;
      2'b11: begin
        sel_a_d = !pick_b;
        sel_b_d = pick_b;
      end
      default: ;
    endcase
    status_d = eff_a | eff_b;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_a  <= 1'b0;
      sel_b  <= 1'b0;
      status <= 1'b0;
    end else begin
      sel_a  <= sel_a_d;
      sel_b  <= sel_b_d;
      status <= status_d;
    end
  end

  // R9
  sel_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_a && sel_b));

  // R9
  tie_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_a && eff_b) |=> (sel_b == $past(pick_b)));
endmodule

// File: rtl/zv_port_ctrl.sv
module zv_port_ctrl
  import zv_pkg::*;
#(
  parameter int DATA_W = ZV_DATA_W,
  parameter int ADDR_W = ZV_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_cfg,
  input  logic              bus_sock,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              port_pick,
  output logic              zv_sel_a,
  output logic              zv_sel_b,
  output logic              zv_status
);
  localparam int NSOCK = ZV_NSOCK;

  logic rst_int_n;
  zv_acc_e acc;
  logic diag_q, diag_d;
  logic std_on;
  logic [NSOCK-1:0] supp, std_en, leg_en, eff_en;
  logic any_eff;
  logic unused_wdata;

  zv_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  always_comb acc = zv_decode(bus_cfg, bus_addr);

  always_comb begin
    diag_d = diag_q;
    if (bus_wr && acc == ACC_DIAG) diag_d = bus_wdata[DIAG_BIT];
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) diag_q <= 1'b0;
    else            diag_q <= diag_d;
  end

  assign std_on = !diag_q;

  for (genvar s = 0; s < NSOCK; s++) begin : g_sock
    logic hit;
    assign hit = bus_wr && (bus_sock == s[0]);
    zv_sock_regs u_regs (
      .clk        (clk),
      .rst_n      (rst_int_n),
      .std_on     (std_on),
      .wr_force   (hit && acc == ACC_FORCE),
      .force_bit  (bus_wdata[SUPP_BIT]),
      .wr_ctrl    (hit && acc == ACC_CTRL),
      .ctrl_bit   (bus_wdata[EN_BIT]),
      .wr_legacy  (hit && acc == ACC_LEGACY),
      .legacy_bit (bus_wdata[LEG_BIT]),
      .supp       (supp[s]),
      .std_en     (std_en[s]),
      .leg_en     (leg_en[s]),
      .eff_en     (eff_en[s])
    );
  end

  assign any_eff = |eff_en;
  assign unused_wdata = ^bus_wdata;

  always_comb begin
    bus_rdata = '0;
    unique case (acc)
      ACC_PRESENT: bus_rdata[SUPP_BIT] = supp[bus_sock];
      ACC_CTRL: begin
        if (std_on) begin
          bus_rdata[EN_BIT]    = std_en[bus_sock];
          bus_rdata[MODEL_BIT] = 1'b1;
          bus_rdata[ACT_BIT]   = any_eff;
        end
      end
      ACC_LEGACY:  bus_rdata[LEG_BIT]  = leg_en[bus_sock];
      ACC_DIAG:    bus_rdata[DIAG_BIT] = diag_q;
      default: ;
    endcase
  end

  zv_sel_encode u_sel (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .eff_a  (eff_en[0]),
    .eff_b  (eff_en[1]),
    .pick_b (port_pick),
    .sel_a  (zv_sel_a),
    .sel_b  (zv_sel_b),
    .status (zv_status)
  );

  // R8
  status_follow_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    1'b1 |=> (zv_status == $past(any_eff)));

  // R1
  present_ro_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_wr && acc == ACC_PRESENT && !(acc == ACC_FORCE)) |=> $stable(supp));
endmodule

// File: tb/sim_zv_port_ctrl.sv
module sim_zv_port_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_cfg, bus_sock, port_pick;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        zv_sel_a, zv_sel_b, zv_status;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  zv_port_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_cfg(bus_cfg),
    .bus_sock(bus_sock), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .port_pick(port_pick),
    .zv_sel_a(zv_sel_a), .zv_sel_b(zv_sel_b), .zv_status(zv_status)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic cfg, input logic sock, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_cfg = cfg; bus_sock = sock; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic cfg, input logic sock, input logic [7:0] a, output logic [31:0] d);
    bus_cfg = cfg; bus_sock = sock; bus_addr = a;
    #2;
    d = bus_rdata;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    rst_n = 1'b1; bus_wr = 0; bus_cfg = 0; bus_sock = 0; bus_addr = 0; bus_wdata = 0; port_pick = 0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R10 outputs low in reset
    chk("R10 status in reset", {31'b0, zv_status}, 0);
    chk("R10 sels in reset", {30'b0, zv_sel_a, zv_sel_b}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset value and read-only
    for (int s = 0; s < 2; s++) begin
      rd(0, s[0], 8'h08, r); chk("R1 support after reset", r, 0);
    end
    wr(0, 0, 8'h08, 32'hFFFF_FFFF);
    rd(0, 0, 8'h08, r); chk("R1 direct write ignored", r, 0);

    // R2 force path
    wr(0, 1, 8'h0C, 32'hF7FF_FFFF);
    rd(0, 1, 8'h08, r); chk("R2 zero bit no effect", r, 0);
    wr(0, 1, 8'h0C, 32'h0800_0000);
    rd(0, 1, 8'h08, r); chk("R2 set socket B", r, 32'h0800_0000);
    rd(0, 0, 8'h08, r); chk("R2 socket A untouched", r, 0);
    rd(0, 1, 8'h0C, r); chk("R2 force reads zero", r, 0);
    wr(0, 1, 8'h0C, 32'h0);
    wr(0, 1, 8'h08, 32'h0);
    rd(0, 1, 8'h08, r); chk("R2 sticky", r, 32'h0800_0000);

    // R6 ignored write while model off
    wr(0, 0, 8'h10, 32'h200);
    wr(1, 0, 8'h93, 32'h1);
    rd(1, 0, 8'h93, r); chk("R6 diag readback", r, 1);
    rd(0, 0, 8'h10, r); chk("R6 ctrl reads zero when off", r, 0);
    settle();
    chk("R6 std enable not counted", {31'b0, zv_status}, 0);
    wr(0, 0, 8'h10, 32'h0);
    wr(1, 0, 8'h93, 32'h0);
    rd(0, 0, 8'h10, r); chk("R6 write ignored while off", r, 32'h0E00);
    wr(0, 0, 8'h10, 32'h0);

    // exhaustive sweep R3 R4 R5 R7 R8 R9
    for (int v = 0; v < 64; v++) begin
      logic dg, sa, sb, la, lb, pk, ea, eb, any;
      logic [31:0] ec;
      {dg, sa, sb, la, lb, pk} = v[5:0];
      wr(1, 0, 8'h93, 32'h0);
      wr(0, 0, 8'h10, {22'b0, sa, 9'b0});
      wr(0, 1, 8'h10, {22'b0, sb, 9'b0});
      wr(1, 0, 8'h91, {25'b0, la, 6'b0});
      wr(1, 1, 8'h91, {25'b0, lb, 6'b0});
      wr(1, 0, 8'h93, {31'b0, dg});
      port_pick = pk;
      settle(); settle();
      ea = la | (sa & !dg);
      eb = lb | (sb & !dg);
      any = ea | eb;
      chk("R8 status", {31'b0, zv_status}, {31'b0, any});
      chk("R9 sel_a", {31'b0, zv_sel_a}, {31'b0, ea & (!eb | !pk)});
      chk("R9 sel_b", {31'b0, zv_sel_b}, {31'b0, eb & (!ea | pk)});
      for (int s = 0; s < 2; s++) begin
        logic se;
        se = (s == 0) ? sa : sb;
        ec = dg ? 32'h0 : ({20'b0, any, 1'b1, se, 9'b0});
        rd(0, s[0], 8'h10, r); chk("R3 R4 R5 ctrl word", r, ec);
        rd(1, s[0], 8'h91, r); chk("R7 legacy readback", r, {25'b0, (s == 0) ? la : lb, 6'b0});
      end
    end

    // R10 mid-run reset
    wr(1, 0, 8'h93, 32'h0);
    wr(1, 0, 8'h91, 32'h40);
    settle();
    chk("R10 status before reset", {31'b0, zv_status}, 1);
    #3 rst_n = 1'b0;
    #2;
    chk("R10 immediate clear", {29'b0, zv_status, zv_sel_a, zv_sel_b}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd(1, 0, 8'h91, r); chk("R10 legacy cleared", r, 0);
    rd(0, 1, 8'h08, r); chk("R10 support cleared", r, 0);
    rd(1, 0, 8'h93, r); chk("R10 diag cleared", r, 0);
    rd(0, 0, 8'h10, r); chk("R10 ctrl cleared", r, 32'h400);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule